// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Unit

This unit sits between the interrupt source logic and one processor. It holds a single pending interrupt, made of a source number, a priority and the identity of the source unit that owns it, and it drives that processor's interrupt line. A smaller priority value wins. The value 0xFF is the least favoured level and marks an empty slot or a fully masked processor. Sources offer interrupts on a one-cycle offer port. The unit compares each offer against the processor's current priority and against whatever is already pending. If a better offer displaces the held interrupt, the held interrupt is handed back to its owner on a reject port.

Software drives the unit through four operations. It can set the processor priority, set the priority of the inter-processor interrupt (IPI) request, accept the pending interrupt, or signal end of interrupt. Accept returns the 32-bit interrupt word and acknowledges the interrupt. End of interrupt restores the processor priority and passes the completed number to the source side. The IPI comparator injects the reserved source number 2 whenever the requested IPI priority beats both the processor priority and the pending interrupt. Whenever the processor priority becomes less favoured, a resend pulse asks the sources to offer again anything they hold back.

Top module: `irq_present_unit`

## Requirements
- R1: The interrupt word has the processor priority in bits 31:24 and the pending source number in bits 23:0. Source number 0 means empty. An accept (cpu_op = 2) lowers irq_out at the next clock edge. On that same edge acc_valid pulses for one cycle, and acc_word carries the word as it stood before the accept. The unit then loads the processor priority with the old pending priority, empties the slot and forgets the owner.
- R2: After reset irq_out is low and the slot is empty. The processor priority is 0x00 and the IPI request priority is 0xFF, so an accept returns 0x00000000.
- R3: An offer of priority P is refused, with no state change and no reject, when P >= the processor priority. It is also refused when an interrupt is pending whose priority is <= P.
- R4: An accepted offer records the offered number, priority and owner and raises irq_out. If a source interrupt was already held, it is first rejected to its owner (rej_valid with rej_num and rej_owner for one cycle).
- R5: A set-priority operation (cpu_op = 0, value in bits 7:0) that makes the processor priority more favoured empties the slot when the new value is <= the pending priority. It then lowers irq_out and rejects the held number to its owner if it has one. A pending interrupt that is more favoured than the new value stays.
- R6: A set-IPI operation (cpu_op = 1, value in bits 7:0) fires the IPI when the new value is below both the processor priority and the pending priority. Firing loads source number 2 with no owner and raises irq_out, and any displaced source interrupt is rejected. Source number 2 is never rejected.
- R7: End of interrupt (cpu_op = 3) loads the processor priority from bits 31:24 of the written word. It pulses eoi_valid with eoi_num = bits 23:0 unless that number is 2.
- R8: When a set-priority or end-of-interrupt operation makes the processor priority less favoured, resend_req pulses for one cycle. The IPI condition is also evaluated again against the new priority.
- R9: A CPU operation takes precedence over an offer in the same cycle. offer_stall is high in that cycle and the offer has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_op_valid | input | 1 | A CPU operation is issued this cycle |
| cpu_op | input | 2 | 0 set priority, 1 set IPI priority, 2 accept, 3 end of interrupt |
| cpu_wdata | input | 32 | Operand of the CPU operation |
| acc_valid | output | 1 | Accept result valid (one cycle) |
| acc_word | output | 32 | Interrupt word returned by accept |
| offer_valid | input | 1 | A source offers an interrupt |
| offer_num | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| offer_owner | input | 2 | Source unit that owns the offered number |
| offer_stall | output | 1 | Offer ignored this cycle because of a CPU operation |
| rej_valid | output | 1 | Reject of a displaced interrupt (one cycle) |
| rej_num | output | 24 | Rejected source number |
| rej_owner | output | 2 | Source unit the reject is returned to |
| eoi_valid | output | 1 | End of interrupt forwarded to the sources (one cycle) |
| eoi_num | output | 24 | Completed source number |
| resend_req | output | 1 | Ask the sources to offer held interrupts again |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
An offer and a CPU operation can arrive in the same cycle, and they race for the single pending slot. The bench raises both at once, with an offer that would clearly win and a CPU write that changes nothing. It then checks that offer_stall is high during that cycle, that irq_out stays low afterwards, and that the same offer is taken once it is repeated alone. End of interrupt and IPI firing also combine within one operation: the bench makes the lowered processor priority re-arm a still-requested IPI and checks for resend_req and the raised line together, with no EOI pulse.

// File: rtl/ipu_pkg.sv
package ipu_pkg;

    localparam int          PRIO_W    = 8;
    localparam logic [7:0]  PRIO_NONE = 8'hFF;

    typedef enum logic [1:0] {
        OP_SET_CPPR = 2'd0,
        OP_SET_IPI  = 2'd1,
        OP_ACCEPT   = 2'd2,
        OP_EOI      = 2'd3
    } cpu_op_e;

    // An offer wins if it beats the processor level and any held interrupt.
    function automatic logic offer_wins(input logic [PRIO_W-1:0] prio,
                                        input logic [PRIO_W-1:0] cppr,
                                        input logic              busy,
                                        input logic [PRIO_W-1:0] held_prio);
        return (prio < cppr) && !(busy && (held_prio <= prio));
    endfunction

    // The IPI wins if its level beats the processor level and the held level.
    function automatic logic ipi_wins(input logic [PRIO_W-1:0] req,
                                      input logic [PRIO_W-1:0] cppr,
                                      input logic [PRIO_W-1:0] held_prio);
        return (req < cppr) && (req < held_prio);
    endfunction

endpackage

// File: rtl/ipu_offer_eval.sv
module ipu_offer_eval
    import ipu_pkg::*;
(
    input  logic [PRIO_W-1:0] offer_prio,
    input  logic [PRIO_W-1:0] cppr,
    input  logic              busy,
    input  logic [PRIO_W-1:0] held_prio,
    output logic              take
);
    always_comb take = offer_wins(offer_prio, cppr, busy, held_prio);
endmodule

// File: rtl/ipu_ipi_eval.sv
module ipu_ipi_eval
    import ipu_pkg::*;
(
    input  logic [PRIO_W-1:0] req_prio,
    input  logic [PRIO_W-1:0] cppr,
    input  logic [PRIO_W-1:0] held_prio,
    output logic              fire
);
    always_comb fire = ipi_wins(req_prio, cppr, held_prio);
endmodule

// File: rtl/irq_present_unit.sv
module irq_present_unit
    import ipu_pkg::*;
#(
    parameter int SRC_W   = 24,
    parameter int OWN_W   = 2,
    parameter int IPI_NUM = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cpu_op_valid,
    input  logic [1:0]                cpu_op,
    input  logic [PRIO_W+SRC_W-1:0]   cpu_wdata,
    output logic                      acc_valid,
    output logic [PRIO_W+SRC_W-1:0]   acc_word,
    input  logic                      offer_valid,
    input  logic [SRC_W-1:0]          offer_num,
    input  logic [PRIO_W-1:0]         offer_prio,
    input  logic [OWN_W-1:0]          offer_owner,
    output logic                      offer_stall,
    output logic                      rej_valid,
    output logic [SRC_W-1:0]          rej_num,
    output logic [OWN_W-1:0]          rej_owner,
    output logic                      eoi_valid,
    output logic [SRC_W-1:0]          eoi_num,
    output logic                      resend_req,
    output logic                      irq_out
);
    localparam int               WORD_W = PRIO_W + SRC_W;
    localparam logic [SRC_W-1:0] IPI_ID = SRC_W'(IPI_NUM);

    typedef struct packed {
        logic [SRC_W-1:0]  num;
        logic [PRIO_W-1:0] prio;
        logic              own_vld;
        logic [OWN_W-1:0]  own;
    } slot_t;

    localparam slot_t SLOT_EMPTY = '{num: '0, prio: PRIO_NONE, own_vld: 1'b0, own: '0};

    cpu_op_e           op;
    slot_t             slot_q, slot_n;
    logic [PRIO_W-1:0] cppr_q, cppr_n;
    logic [PRIO_W-1:0] mfrr_q, mfrr_n;
    logic              irq_n;
    logic              busy;
    logic              take, fire;
    logic [PRIO_W-1:0] ipi_req, ipi_cppr;
    logic [PRIO_W-1:0] wr_low, wr_high;
    logic [SRC_W-1:0]  wr_num;

    logic              rej_n, eoi_n, resend_n, acc_n;
    logic [SRC_W-1:0]  rej_num_n;
    logic [OWN_W-1:0]  rej_own_n;

    always_comb begin
        op      = cpu_op_e'(cpu_op);
        busy    = (slot_q.num != '0);
        wr_low  = cpu_wdata[PRIO_W-1:0];
        wr_high = cpu_wdata[WORD_W-1 -: PRIO_W];
        wr_num  = cpu_wdata[SRC_W-1:0];
        ipi_req = (op == OP_SET_IPI) ? wr_low : mfrr_q;
        case (op)
            OP_SET_IPI: ipi_cppr = cppr_q;
            OP_EOI:     ipi_cppr = wr_high;
            default:    ipi_cppr = wr_low;
        endcase
    end

    ipu_offer_eval u_offer (
        .offer_prio (offer_prio),
        .cppr       (cppr_q),
        .busy       (busy),
        .held_prio  (slot_q.prio),
        .take       (take)
    );

    ipu_ipi_eval u_ipi (
        .req_prio  (ipi_req),
        .cppr      (ipi_cppr),
        .held_prio (slot_q.prio),
        .fire      (fire)
    );

    assign offer_stall = cpu_op_valid;

    always_comb begin
        slot_n    = slot_q;
        cppr_n    = cppr_q;
        mfrr_n    = mfrr_q;
        irq_n     = irq_out;
        rej_n     = 1'b0;
        rej_num_n = slot_q.num;
        rej_own_n = slot_q.own;
        eoi_n     = 1'b0;
        resend_n  = 1'b0;
        acc_n     = 1'b0;

        if (cpu_op_valid) begin
            case (op)
                OP_SET_CPPR: begin
                    cppr_n = wr_low;
                    if (wr_low < cppr_q) begin
                        if (busy && (wr_low <= slot_q.prio)) begin
                            rej_n  = slot_q.own_vld;
                            slot_n = SLOT_EMPTY;
                            irq_n  = 1'b0;
                        end
                    end else if (wr_low > cppr_q) begin
                        resend_n = 1'b1;
                    end
                end
                OP_SET_IPI: begin
                    mfrr_n = wr_low;
                end
                OP_ACCEPT: begin
                    acc_n  = 1'b1;
                    cppr_n = slot_q.prio;
                    slot_n = SLOT_EMPTY;
                    irq_n  = 1'b0;
                end
                default: begin
                    cppr_n   = wr_high;
                    eoi_n    = (wr_num != IPI_ID);
                    resend_n = (wr_high > cppr_q);
                end
            endcase

            // The IPI is (re)checked on an IPI write or a loosened priority.
            if (fire && ((op == OP_SET_IPI) || resend_n)) begin
                rej_n  = busy && slot_q.own_vld;
                slot_n = '{num: IPI_ID, prio: ipi_req, own_vld: 1'b0, own: '0};
                irq_n  = 1'b1;
            end
        end else if (offer_valid && take) begin
            rej_n  = busy && slot_q.own_vld;
            slot_n = '{num: offer_num, prio: offer_prio, own_vld: 1'b1, own: offer_owner};
            irq_n  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q     <= SLOT_EMPTY;
            cppr_q     <= '0;
            mfrr_q     <= PRIO_NONE;
            irq_out    <= 1'b0;
            rej_valid  <= 1'b0;
            rej_num    <= '0;
            rej_owner  <= '0;
            eoi_valid  <= 1'b0;
            eoi_num    <= '0;
            resend_req <= 1'b0;
            acc_valid  <= 1'b0;
            acc_word   <= '0;
        end else begin
            slot_q     <= slot_n;
            cppr_q     <= cppr_n;
            mfrr_q     <= mfrr_n;
            irq_out    <= irq_n;
            rej_valid  <= rej_n;
            rej_num    <= rej_num_n;
            rej_owner  <= rej_own_n;
            eoi_valid  <= eoi_n;
            eoi_num    <= wr_num;
            resend_req <= resend_n;
            acc_valid  <= acc_n;
            acc_word   <= acc_n ? {cppr_q, slot_q.num} : acc_word;
        end
    end

    // Plain views of state for the bound checker.
    logic [PRIO_W-1:0] held_prio_view;
    logic [SRC_W-1:0]  held_num_view;
    assign held_prio_view = slot_q.prio;
    assign held_num_view  = slot_q.num;

endmodule

// File: rtl/ipu_checker.sv
module ipu_checker #(
    parameter int SRC_W   = 24,
    parameter int IPI_NUM = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_op_valid,
    input logic [1:0]       cpu_op,
    input logic             offer_valid,
    input logic [7:0]       offer_prio,
    input logic             offer_stall,
    input logic             irq_out,
    input logic             rej_valid,
    input logic [SRC_W-1:0] rej_num,
    input logic             eoi_valid,
    input logic [SRC_W-1:0] eoi_num,
    input logic             resend_req,
    input logic             acc_valid,
    input logic [7:0]       cppr,
    input logic [7:0]       held_prio,
    input logic [SRC_W-1:0] held_num
);
    localparam logic [SRC_W-1:0] IPI_ID = SRC_W'(IPI_NUM);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !irq_out && !rej_valid); // R2

    AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (rst)
        cpu_op_valid && (cpu_op == 2'd2) |=> !irq_out && acc_valid); // R1

    AST_REFUSED_OFFER: assert property (@(posedge clk) disable iff (rst)
        offer_valid && !cpu_op_valid && (offer_prio >= cppr) |=> !rej_valid && $stable(held_num)); // R3

    AST_LINE_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (held_num != '0) && (held_prio != 8'hFF)); // R4

    AST_NO_IPI_REJECT: assert property (@(posedge clk) disable iff (rst)
        rej_valid |-> rej_num != IPI_ID); // R6

    AST_EOI_SKIPS_IPI: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> eoi_num != IPI_ID); // R7

    AST_RESEND_FROM_OP: assert property (@(posedge clk) disable iff (rst)
        resend_req |-> $past(cpu_op_valid)); // R8

    AST_OFFER_STALLED: assert property (@(posedge clk) disable iff (rst)
        cpu_op_valid |-> offer_stall); // R9
endmodule

bind irq_present_unit ipu_checker #(.SRC_W(SRC_W), .IPI_NUM(IPI_NUM)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_op_valid (cpu_op_valid),
    .cpu_op       (cpu_op),
    .offer_valid  (offer_valid),
    .offer_prio   (offer_prio),
    .offer_stall  (offer_stall),
    .irq_out      (irq_out),
    .rej_valid    (rej_valid),
    .rej_num      (rej_num),
    .eoi_valid    (eoi_valid),
    .eoi_num      (eoi_num),
    .resend_req   (resend_req),
    .acc_valid    (acc_valid),
    .cppr         (cppr_q),
    .held_prio    (held_prio_view),
    .held_num     (held_num_view)
);

// File: tb/irq_present_unit_bench.sv
module irq_present_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_op_valid = 1'b0;
    logic [1:0]  cpu_op = 2'd0;
    logic [31:0] cpu_wdata = '0;
    logic        acc_valid;
    logic [31:0] acc_word;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_num = '0;
    logic [7:0]  offer_prio = '0;
    logic [1:0]  offer_owner = '0;
    logic        offer_stall;
    logic        rej_valid;
    logic [23:0] rej_num;
    logic [1:0]  rej_owner;
    logic        eoi_valid;
    logic [23:0] eoi_num;
    logic        resend_req;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_present_unit u_irq_present_unit (
        .clk(clk), .rst(rst),
        .cpu_op_valid(cpu_op_valid), .cpu_op(cpu_op), .cpu_wdata(cpu_wdata),
        .acc_valid(acc_valid), .acc_word(acc_word),
        .offer_valid(offer_valid), .offer_num(offer_num), .offer_prio(offer_prio),
        .offer_owner(offer_owner), .offer_stall(offer_stall),
        .rej_valid(rej_valid), .rej_num(rej_num), .rej_owner(rej_owner),
        .eoi_valid(eoi_valid), .eoi_num(eoi_num),
        .resend_req(resend_req), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cpu(input logic [1:0] op, input logic [31:0] data);
        @(negedge clk);
        cpu_op_valid = 1'b1; cpu_op = op; cpu_wdata = data;
        @(negedge clk);
        cpu_op_valid = 1'b0;
    endtask

    task automatic offer(input logic [23:0] num, input logic [7:0] prio, input logic [1:0] own);
        @(negedge clk);
        offer_valid = 1'b1; offer_num = num; offer_prio = prio; offer_owner = own;
        @(negedge clk);
        offer_valid = 1'b0;
    endtask

    task automatic accept_expect(input string tag, input logic [31:0] exp);
        cpu(2'd2, 32'h0);
        check({tag, " acc_valid"}, 32'(acc_valid), 32'd1);
        check({tag, " acc_word"}, acc_word, exp);
        check({tag, " irq low"}, 32'(irq_out), 32'd0);
    endtask

    task automatic t_reset;
        check("R2 irq after reset", 32'(irq_out), 32'd0);
        check("R2 no reject after reset", 32'(rej_valid), 32'd0);
        check("R2 no resend after reset", 32'(resend_req), 32'd0);
        // processor level 0 masks everything: R3 refusal at P >= level
        offer(24'h10, 8'h05, 2'd1);
        check("R3 offer refused at level 0", 32'(irq_out), 32'd0);
        check("R3 no reject on refusal", 32'(rej_valid), 32'd0);
        accept_expect("R2 reset word", 32'h0000_0000);
    endtask

    task automatic t_preempt;
        offer(24'h10, 8'h05, 2'd1);
        check("R4 offer raises line", 32'(irq_out), 32'd1);
        check("R4 first offer no reject", 32'(rej_valid), 32'd0);
        offer(24'h20, 8'h05, 2'd2);
        check("R3 equal priority refused", 32'(rej_valid), 32'd0);
        offer(24'h30, 8'h03, 2'd2);
        check("R4 displaced reject", 32'(rej_valid), 32'd1);
        check("R4 rejected number", 32'(rej_num), 32'h10);
        check("R4 rejected owner", 32'(rej_owner), 32'd1);
        check("R4 line held", 32'(irq_out), 32'd1);
        accept_expect("R1 accept preempting offer", 32'hFF00_0030);
        offer(24'h40, 8'h03, 2'd0);
        check("R3 offer equal to processor level refused", 32'(irq_out), 32'd0);
        cpu(2'd3, 32'hFF00_0030);
        check("R7 eoi forwarded", 32'(eoi_valid), 32'd1);
        check("R7 eoi number", 32'(eoi_num), 32'h30);
        check("R8 resend on loosened level", 32'(resend_req), 32'd1);
    endtask

    task automatic t_cppr_clear;
        offer(24'h40, 8'h06, 2'd3);
        check("R4 offer taken", 32'(irq_out), 32'd1);
        cpu(2'd0, 32'h0000_0004);
        check("R5 line lowered", 32'(irq_out), 32'd0);
        check("R5 reject issued", 32'(rej_valid), 32'd1);
        check("R5 reject number", 32'(rej_num), 32'h40);
        check("R5 reject owner", 32'(rej_owner), 32'd3);
        check("R8 no resend when tightened", 32'(resend_req), 32'd0);
        accept_expect("R5 slot emptied", 32'h0400_0000);
        offer(24'h50, 8'h02, 2'd1);
        cpu(2'd0, 32'h0000_0004);
        check("R5 more favoured pending stays", 32'(irq_out), 32'd1);
        check("R5 no reject for kept pending", 32'(rej_valid), 32'd0);
        accept_expect("R1 word after tighten", 32'h0400_0050);
        cpu(2'd3, 32'hFF00_0050);
        check("R7 eoi number 0x50", 32'(eoi_num), 32'h50);
        check("R7 eoi pulse", 32'(eoi_valid), 32'd1);
    endtask

    task automatic t_ipi;
        offer(24'h60, 8'h07, 2'd0);
        cpu(2'd1, 32'h0000_0003);
        check("R6 ipi displaces source", 32'(rej_valid), 32'd1);
        check("R6 displaced number", 32'(rej_num), 32'h60);
        check("R6 line raised", 32'(irq_out), 32'd1);
        accept_expect("R6 ipi number 2", 32'hFF00_0002);
        cpu(2'd3, 32'hFF00_0002);
        check("R7 no eoi for ipi", 32'(eoi_valid), 32'd0);
        check("R8 resend on eoi", 32'(resend_req), 32'd1);
        check("R8 ipi re-armed", 32'(irq_out), 32'd1);
        check("R6 ipi has no owner to reject", 32'(rej_valid), 32'd0);
        accept_expect("R8 re-armed ipi word", 32'hFF00_0002);
        cpu(2'd1, 32'h0000_00FF);
        cpu(2'd3, 32'hFF00_0002);
        check("R8 no ipi after request cleared", 32'(irq_out), 32'd0);
        cpu(2'd0, 32'h0000_0005);
        cpu(2'd1, 32'h0000_0005);
        check("R6 ipi equal to level does not fire", 32'(irq_out), 32'd0);
        cpu(2'd1, 32'h0000_0004);
        check("R6 ipi below level fires", 32'(irq_out), 32'd1);
        accept_expect("R6 ipi word at level 5", 32'h0500_0002);
        cpu(2'd1, 32'h0000_00FF);
        cpu(2'd3, 32'hFF00_0002);
        check("R8 line idle after final eoi", 32'(irq_out), 32'd0);
    endtask

    task automatic t_collide;
        @(negedge clk);
        cpu_op_valid = 1'b1; cpu_op = 2'd1; cpu_wdata = 32'h0000_00FF;
        offer_valid = 1'b1; offer_num = 24'h70; offer_prio = 8'h01; offer_owner = 2'd2;
        #1;
        check("R9 stall during cpu op", 32'(offer_stall), 32'd1);
        @(negedge clk);
        cpu_op_valid = 1'b0; offer_valid = 1'b0;
        check("R9 offer ignored", 32'(irq_out), 32'd0);
        check("R9 stall released", 32'(offer_stall), 32'd0);
        offer(24'h70, 8'h01, 2'd2);
        check("R9 retried offer taken", 32'(irq_out), 32'd1);
        accept_expect("R9 retried word", 32'hFF00_0070);
        cpu(2'd3, 32'hFF00_0070);
        check("R7 eoi 0x70", 32'(eoi_num), 32'h70);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_preempt;
        t_cppr_clear;
        t_ipi;
        t_collide;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule